// File: doc/BRIEF.md
# DMA Channel Bus-Mastership Sequencer

This block is one DMA channel. It waits for an active-low request from a peripheral and asks the system bus arbiter for mastership. When the bus is granted, it moves one transfer unit and then either returns the bus or keeps it. In cycle-steal mode the bus goes back after every unit, so the channel must win arbitration again for the next unit. In burst mode the channel keeps the bus until its unit count runs out.

Each unit can be moved in one of two ways. A dual-address move reads the source and then writes the read data to the destination. A single-address move drives the acknowledge pin low so that an external device takes part in the memory cycle directly. In one direction the device supplies the data and memory is written. In the other direction memory is read and the device captures the data.

Software programs four registers through a simple write port: source address, destination address, unit count and channel control. It then sets the enable bit. The channel clears the enable bit and raises a done flag after the last unit.

Top module: `dma_mastership_seq`

## Requirements
- R1: After reset the outputs are idle: `busReq` low, `dackN` high, `memRd` and `memWr` low, and `done` low.
- R2: Nothing starts while `dreqN` is high (the request is level-sensitive and active low). An enabled channel then keeps `busReq` low and issues no memory cycle.
- R3: A dual-address unit is a read at the source address, followed in the next cycle by a write of that same data to the destination address. `dackN` stays high. The read and write strobes are never high together.
- R4: Cycle-steal mode (control bit 1 = 0) drops `busReq` after each completed unit. The next unit starts with a fresh request once `dreqN` is low.
- R5: Burst mode (control bit 1 = 1) holds `busReq` high across all units and drops it exactly once, after the last unit.
- R6: The unit size code in control bits [3:2] selects 0 = byte, 1 = 16-bit, 2 = 32-bit, 3 = 16-byte. `memSize` carries 0, 1 or 2, and 2 for the beats of a 16-byte unit. An incrementing address advances by 1, 2, 4 or 4 bytes per beat.
- R7: A 16-byte unit is four consecutive 32-bit beats with no bus release between them, even in cycle-steal mode.
- R8: The source address advances only when control bit 4 is set, and the destination address advances only when control bit 5 is set. Otherwise the address stays fixed for every beat.
- R9: The count register (offset 2) is decremented once per unit. When it reaches zero the channel sets `done`, clears its enable bit and starts no further unit, even with `dreqN` still low. A write to the control register clears `done`.
- R10: Single-address device-to-memory (control bit 6 = 1, bit 7 = 0) drives `dackN` low during a memory write at the destination address, with `memWdata` equal to `devWdata`.
- R11: Single-address memory-to-device (control bit 6 = 1, bit 7 = 1) drives `dackN` low during a memory read at the source address.
- R12: The register offsets are 0 = source address, 1 = destination address, 2 = unit count and 3 = control, with bit 0 of the control register as the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 2 | Register offset |
| cfgWdata | input | 32 | Register write data |
| dreqN | input | 1 | Active-low transfer request from the peripheral |
| dackN | output | 1 | Active-low acknowledge to the peripheral during single-address cycles |
| busReq | output | 1 | Bus mastership request |
| busGnt | input | 1 | Bus mastership grant |
| memAddr | output | 32 | Memory byte address |
| memRd | output | 1 | Memory read strobe (one-cycle access) |
| memWr | output | 1 | Memory write strobe (one-cycle access) |
| memSize | output | 2 | Access size code: 0 byte, 1 16-bit, 2 32-bit |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid in the read cycle |
| devWdata | input | 32 | Data from the device in single-address device-to-memory cycles |
| done | output | 1 | Sticky flag: the count reached zero |

## Verification
The arbiter model in the bench grants one cycle after `busReq` rises and withdraws the grant one cycle after it falls, so a unit's first strobe is due two cycles after the channel leaves idle. In a dual-address beat the write follows its read by exactly one cycle. A scoreboard therefore compares each strobe, in order, against a queue of expected cycles, sampling on the falling edge after the strobe appears. Bus releases are counted from `busReq` falling edges and compared once `done` is seen. The idle checks for R2 and R9 wait ten cycles, so that any strobe appearing in that window is reported.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  // Control register image, bit 0 first: en, burst, size[1:0], srcInc, dstInc, single, toDev
  typedef struct packed {
    logic       toDev;
    logic       single;
    logic       dstInc;
    logic       srcInc;
    logic [1:0] size;
    logic       burst;
    logic       en;
  } chanCfg_t;

  typedef struct packed {
    logic captureData;
    logic stepSrc;
    logic stepDst;
    logic decCount;
    logic finish;
    logic selDst;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_RD,
    ST_WR,
    ST_SGL
  } seqState_t;

  localparam logic [1:0] REG_SRC  = 2'd0;
  localparam logic [1:0] REG_DST  = 2'd1;
  localparam logic [1:0] REG_CNT  = 2'd2;
  localparam logic [1:0] REG_CTRL = 2'd3;

  localparam logic [1:0] SZ_BLOCK = 2'd3;

endpackage

// File: rtl/dma_seq_datapath.sv
module dma_seq_datapath
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [1:0]    cfgAddr,
  input  logic [31:0]   cfgWdata,
  input  dpStrobe_t     strobe,
  input  logic [DW-1:0] memRdata,
  input  logic [DW-1:0] devWdata,
  output chanCfg_t      cfg,
  output logic          cntIsOne,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic [1:0]    memSize,
  output logic          done
);

  localparam int CFGW = $bits(chanCfg_t);

  logic [AW-1:0]   srcAddr;
  logic [AW-1:0]   dstAddr;
  logic [CW-1:0]   xferCnt;
  logic [CFGW-1:0] ctrlReg;
  logic [DW-1:0]   dataHold;
  logic            doneFlag;
  logic [AW-1:0]   stepBytes;

  assign cfg = chanCfg_t'(ctrlReg);

  always_comb begin
    unique case (cfg.size)
      2'd0:    stepBytes = AW'(1);
      2'd1:    stepBytes = AW'(2);
      default: stepBytes = AW'(4);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcAddr  <= '0;
      dstAddr  <= '0;
      xferCnt  <= '0;
      ctrlReg  <= '0;
      dataHold <= '0;
      doneFlag <= 1'b0;
    end else begin
      if (strobe.captureData) dataHold <= memRdata;
      if (strobe.stepSrc && cfg.srcInc) srcAddr <= srcAddr + stepBytes;
      if (strobe.stepDst && cfg.dstInc) dstAddr <= dstAddr + stepBytes;
      if (strobe.decCount) xferCnt <= xferCnt - CW'(1);
      if (strobe.finish) begin
        ctrlReg[0] <= 1'b0;
        doneFlag   <= 1'b1;
      end
      if (cfgWe) begin
        unique case (cfgAddr)
          REG_SRC: srcAddr <= AW'(cfgWdata);
          REG_DST: dstAddr <= AW'(cfgWdata);
          REG_CNT: xferCnt <= CW'(cfgWdata);
          default: begin
            ctrlReg  <= cfgWdata[CFGW-1:0];
            doneFlag <= 1'b0;
          end
        endcase
      end
    end
  end

  assign cntIsOne = (xferCnt == CW'(1));
  assign memAddr  = strobe.selDst ? dstAddr : srcAddr;
  assign memWdata = cfg.single ? devWdata : dataHold;
  assign memSize  = (cfg.size == SZ_BLOCK) ? 2'd2 : cfg.size;
  assign done     = doneFlag;

  // R9
  done_clears_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> !cfg.en);

  // R9
  count_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.decCount && !cfgWe) |=> (xferCnt == $past(xferCnt) - CW'(1)));

  // R8
  src_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.srcInc && !cfgWe) |=> $stable(srcAddr));

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  chanCfg_t  cfg,
  input  logic      cntIsOne,
  input  logic      dreqN,
  input  logic      busGnt,
  output logic      busReq,
  output logic      dackN,
  output logic      memRd,
  output logic      memWr,
  output dpStrobe_t strobe
);

  seqState_t state, stateNxt;
  logic [1:0] beatCnt, beatNxt;
  logic       beatEnd;
  logic       lastBeat;
  seqState_t  firstState;

  assign beatEnd    = (state == ST_WR) || (state == ST_SGL);
  assign lastBeat   = (cfg.size != SZ_BLOCK) || (beatCnt == 2'd3);
  assign firstState = cfg.single ? ST_SGL : ST_RD;

  always_comb begin
    stateNxt = state;
    beatNxt  = beatCnt;
    unique case (state)
      ST_IDLE: if (cfg.en && !dreqN) stateNxt = ST_ARB;
      ST_ARB:  if (busGnt) stateNxt = firstState;
      ST_RD:   stateNxt = ST_WR;
      default: begin
        if (!lastBeat) begin
          beatNxt  = beatCnt + 2'd1;
          stateNxt = firstState;
        end else begin
          beatNxt = 2'd0;
          if (cntIsOne)       stateNxt = ST_IDLE;
          else if (cfg.burst) stateNxt = firstState;
          else                stateNxt = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      beatCnt <= 2'd0;
    end else begin
      state   <= stateNxt;
      beatCnt <= beatNxt;
    end
  end

  always_comb begin
    strobe = '0;
    memRd  = 1'b0;
    memWr  = 1'b0;
    unique case (state)
      ST_RD: begin
        memRd              = 1'b1;
        strobe.captureData = 1'b1;
        strobe.stepSrc     = 1'b1;
      end
      ST_WR: begin
        memWr          = 1'b1;
        strobe.selDst  = 1'b1;
        strobe.stepDst = 1'b1;
      end
      ST_SGL: begin
        if (cfg.toDev) begin
          memRd          = 1'b1;
          strobe.stepSrc = 1'b1;
        end else begin
          memWr          = 1'b1;
          strobe.selDst  = 1'b1;
          strobe.stepDst = 1'b1;
        end
      end
      default: ;
    endcase
    if (beatEnd && lastBeat) begin
      strobe.decCount = 1'b1;
      strobe.finish   = cntIsOne;
    end
  end

  assign busReq = (state != ST_IDLE);
  assign dackN  = (state != ST_SGL);

  // R3
  rdwr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  // R4
  steal_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beatEnd && lastBeat && !cfg.burst) |=> !busReq);

  // R5
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beatEnd && lastBeat && cfg.burst && !cntIsOne) |=> busReq);

  // R7
  block_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beatEnd && !lastBeat) |=> (busReq && (memRd || memWr)));

  // R10
  dack_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dackN |-> (cfg.single && (memRd || memWr)));

  // R3
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && dackN) |=> (memWr && dackN));

endmodule

// File: rtl/dma_mastership_seq.sv
module dma_mastership_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [1:0]    cfgAddr,
  input  logic [31:0]   cfgWdata,
  input  logic          dreqN,
  output logic          dackN,
  output logic          busReq,
  input  logic          busGnt,
  output logic [AW-1:0] memAddr,
  output logic          memRd,
  output logic          memWr,
  output logic [1:0]    memSize,
  output logic [DW-1:0] memWdata,
  input  logic [DW-1:0] memRdata,
  input  logic [DW-1:0] devWdata,
  output logic          done
);

  chanCfg_t  cfg;
  dpStrobe_t strobe;
  logic      cntIsOne;

  dma_seq_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cfg      (cfg),
    .cntIsOne (cntIsOne),
    .dreqN    (dreqN),
    .busGnt   (busGnt),
    .busReq   (busReq),
    .dackN    (dackN),
    .memRd    (memRd),
    .memWr    (memWr),
    .strobe   (strobe)
  );

  dma_seq_datapath #(.AW(AW), .DW(DW), .CW(CW)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .cfgWdata (cfgWdata),
    .strobe   (strobe),
    .memRdata (memRdata),
    .devWdata (devWdata),
    .cfg      (cfg),
    .cntIsOne (cntIsOne),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memSize  (memSize),
    .done     (done)
  );

endmodule

// File: tb/dma_mastership_seq_tb_top.sv
module dma_mastership_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgAddr = 2'd0;
  logic [31:0] cfgWdata = '0;
  logic        dreqN = 1'b1;
  logic        dackN;
  logic        busReq;
  logic        busGnt;
  logic [31:0] memAddr;
  logic        memRd;
  logic        memWr;
  logic [1:0]  memSize;
  logic [31:0] memWdata;
  logic [31:0] memRdata;
  logic [31:0] devWdata = '0;
  logic        done;

  int checks = 0;
  int failures = 0;
  int releases = 0;
  logic prevReq = 1'b0;

  typedef struct {
    logic        isRd;
    logic [31:0] addr;
    logic [31:0] data;
    logic [1:0]  size;
    logic        dack;
    string       tag;
  } expOp_t;

  expOp_t expQ[$];

  always #2 clk = ~clk;

  dma_mastership_seq dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .dreqN(dreqN), .dackN(dackN), .busReq(busReq), .busGnt(busGnt),
    .memAddr(memAddr), .memRd(memRd), .memWr(memWr), .memSize(memSize),
    .memWdata(memWdata), .memRdata(memRdata), .devWdata(devWdata), .done(done)
  );

  function automatic logic [31:0] memVal(input logic [31:0] a);
    return (a * 32'h0100_0193) ^ 32'h5A5A_0F0F;
  endfunction

  assign memRdata = memVal(memAddr);

  // Arbiter model: grant follows request by one cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busGnt <= 1'b0;
    else       busGnt <= busReq;
  end

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: compares each memory strobe with the scoreboard head
  always @(negedge clk) begin
    if (rstN) begin
      if (prevReq && !busReq) releases++;
      prevReq = busReq;
      if (memRd || memWr) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R2/R9", "unexpected memory cycle at", memAddr, 32'h0);
        end else begin
          expOp_t e;
          e = expQ.pop_front();
          chk(memRd == e.isRd, e.tag, "read strobe", 32'(memRd), 32'(e.isRd));
          chk(memAddr == e.addr, e.tag, "address", memAddr, e.addr);
          chk(memSize == e.size, e.tag, "size code", 32'(memSize), 32'(e.size));
          chk(!dackN == e.dack, e.tag, "dack active", 32'(!dackN), 32'(e.dack));
          if (!e.isRd) chk(memWdata == e.data, e.tag, "write data", memWdata, e.data);
        end
      end
    end
  end

  task automatic cfgWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic pushOp(input logic isRd, input logic [31:0] a, input logic [31:0] d,
                        input logic [1:0] sz, input logic dk, input string tag);
    expOp_t e;
    e.isRd = isRd; e.addr = a; e.data = d; e.size = sz; e.dack = dk; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic runCase(input string tag, input logic [31:0] src, input logic [31:0] dst,
                         input int cnt, input logic [1:0] size, input logic burst,
                         input logic si, input logic di, input logic single, input logic toDev);
    logic [31:0] sa, da, step;
    logic [1:0]  szc;
    int beats, t;
    sa = src; da = dst;
    beats = (size == 2'd3) ? 4 : 1;
    step  = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
    szc   = (size == 2'd3) ? 2'd2 : size;
    for (int u = 0; u < cnt; u++) begin
      for (int b = 0; b < beats; b++) begin
        if (!single) begin
          pushOp(1'b1, sa, 32'h0, szc, 1'b0, tag);
          pushOp(1'b0, da, memVal(sa), szc, 1'b0, tag);
          if (si) sa += step;
          if (di) da += step;
        end else if (toDev) begin
          pushOp(1'b1, sa, 32'h0, szc, 1'b1, tag);
          if (si) sa += step;
        end else begin
          pushOp(1'b0, da, devWdata, szc, 1'b1, tag);
          if (di) da += step;
        end
      end
    end
    cfgWrite(2'd0, src);
    cfgWrite(2'd1, dst);
    cfgWrite(2'd2, 32'(cnt));
    releases = 0;
    cfgWrite(2'd3, {24'h0, toDev, single, di, si, size, burst, 1'b1});
    dreqN = 1'b0;
    t = 0;
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(done == 1'b1, "R9", "done flag", 32'(done), 32'h1);
    repeat (10) @(negedge clk);
    chk(busReq == 1'b0, "R9", "no request after count end", 32'(busReq), 32'h0);
    chk(expQ.size() == 0, tag, "missing memory cycles", 32'(expQ.size()), 32'h0);
    chk(releases == (burst ? 1 : cnt), burst ? "R5" : "R4", "bus releases",
        32'(releases), 32'(burst ? 1 : cnt));
    dreqN = 1'b1;
    expQ.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busReq == 1'b0, "R1", "busReq", 32'(busReq), 32'h0);
    chk(dackN == 1'b1, "R1", "dackN", 32'(dackN), 32'h1);
    chk(!memRd && !memWr, "R1", "strobes", {30'h0, memRd, memWr}, 32'h0);
    chk(done == 1'b0, "R1", "done", 32'(done), 32'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2: enabled channel with no request stays idle (R12 register layout)
    cfgWrite(2'd0, 32'h100);
    cfgWrite(2'd1, 32'h200);
    cfgWrite(2'd2, 32'd2);
    cfgWrite(2'd3, 32'h0000_0009);
    repeat (10) @(negedge clk);
    chk(busReq == 1'b0, "R2", "request while dreqN high", 32'(busReq), 32'h0);
    chk(done == 1'b0, "R2", "done while dreqN high", 32'(done), 32'h0);
    cfgWrite(2'd3, 32'h0);

    // R3 R4 R6: dual, 32-bit, cycle-steal, both increment
    runCase("R3", 32'h1000, 32'h2000, 3, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    // R5 R8 R6: dual, byte, burst, source increments only
    runCase("R5", 32'h1103, 32'h2200, 4, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    // R8 R6: dual, 16-bit, cycle-steal, fixed addresses
    runCase("R8", 32'h1400, 32'h2402, 2, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R7: 16-byte units in cycle-steal mode
    runCase("R7", 32'h3000, 32'h4000, 2, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    // R10: single-address device to memory, burst
    devWdata = 32'hC0DE_1234;
    runCase("R10", 32'h0, 32'h5000, 3, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    // R11: single-address memory to device, 16-bit cycle-steal
    runCase("R11", 32'h6000, 32'h0, 2, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    // R9: control write clears done
    cfgWrite(2'd3, 32'h0);
    chk(done == 1'b0, "R9", "done after control write", 32'(done), 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule